// File: doc/BRIEF.md
# Scatter Segment Descriptor Splitter

This block turns a stream of scatter segments into the descriptor table that a bus-master disk controller walks. Each segment is a 32-bit bus address and a byte length. Each descriptor leaves the block as two 32-bit words: the buffer address first, then a count word. No descriptor may span a 64 KiB address boundary, so every segment is cut into pieces at those boundaries. A piece that would cover a whole 64 KiB window is emitted as two 32 KiB descriptors, because some controllers read a zero count field as zero bytes rather than 64 KiB.

The count word has two encodings, chosen with `alt_mode`. In the standard encoding the byte count sits in the low half, and bit 31 marks the final descriptor of the table. In the alternate encoding the upper half holds the number of 32-bit words minus one, and there is no end marker. Because the end bit can only be placed once the last input segment is known, one descriptor is always held back inside the block until the next one arrives or the table closes.

The table size is limited by a parameter. If the limit is exceeded the table is abandoned and an overflow error is pulsed. A table that produces no descriptors gives an empty-table error. A completed table gives a done pulse together with its descriptor count.

Top module: `sg_prd_splitter`

## Requirements
- R1: Every descriptor covers min(remaining segment length, 0x10000 minus the low 16 address bits) bytes, so that no descriptor crosses a 64 KiB boundary. The current address advances by that amount and the remaining length shrinks by it.
- R2: Each descriptor is sent as two words in this order: the buffer address, then the count word. In standard mode the byte count is in count-word bits 15:0.
- R3: A piece of exactly 0x10000 bytes is sent as two descriptors of 0x8000 bytes each, at the piece address and at the piece address plus 0x8000.
- R4: Segments are consumed in arrival order. A zero-length segment that is not flagged last yields no descriptor and does not disturb the table.
- R5: In standard mode (`alt_mode`=0), count-word bit 31 is 1 on the final descriptor of a completed table and 0 on all others, and bits 30:16 are 0. A zero-length last segment marks the descriptor sent before it as final.
- R6: In alternate mode (`alt_mode`=1), count-word bits 31:16 equal (bytes/4)-1, bits 15:0 are 0, and no end marker is added.
- R7: When a table needs more than MAX_ENTRIES descriptors (both 32 KiB halves counting), `err_overflow` pulses for one cycle. Only the first MAX_ENTRIES-1 descriptors are sent, none with an end marker. The remaining segments up to and including the one flagged last are accepted without output.
- R8: A table whose segments all have zero length gives a one-cycle `err_empty` pulse with `desc_count`=0, and no output words.
- R9: One cycle after the count word of the final descriptor is accepted, `done` pulses for one cycle with `desc_count` equal to the number of descriptors in the table. At most one of `done`, `err_overflow` and `err_empty` is high in any cycle.
- R10: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` stays stable.
- R11: After reset, `word_valid`, `done`, `err_overflow` and `err_empty` are 0, `desc_count` is 0 and `seg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_mode | input | 1 | Count-word encoding: 0 standard, 1 alternate; hold steady within a table |
| seg_valid | input | 1 | A segment is offered |
| seg_ready | output | 1 | The block accepts the offered segment |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | This segment closes the table |
| word_valid | output | 1 | A descriptor word is offered |
| word_ready | input | 1 | The consumer takes the offered word |
| word_data | output | 32 | Descriptor word: address or count word |
| done | output | 1 | One-cycle pulse: the table completed |
| err_overflow | output | 1 | One-cycle pulse: the table exceeded MAX_ENTRIES |
| err_empty | output | 1 | One-cycle pulse: the table had no descriptors |
| desc_count | output | $clog2(MAX_ENTRIES+1) | Descriptor count of the last completed table, 0 after an empty table |

## Verification
The bench builds the block with MAX_ENTRIES=6 and LEN_W=20. A limit of six makes it cheap to build a table that fills the limit exactly with split 64 KiB halves. It also makes it cheap to build tables that go one past the limit, either on a whole piece or on the second half of a split. The 20-bit length lets a single segment span several 64 KiB windows, so one input yields many split descriptors. Tables run both with the consumer always ready and with intermittent backpressure.

// File: rtl/sgprd_pkg.sv
package sgprd_pkg;

    localparam logic [16:0] WINDOW_BYTES = 17'h10000;
    localparam logic [15:0] HALF_BYTES   = 16'h8000;

    // One descriptor on its way through the pipeline.
    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] nbytes;
        logic        tail;      // final descriptor of the table
        logic        has_data;  // 0: marker that only closes the table
    } piece_t;

    typedef enum logic [2:0] {
        G_IDLE,
        G_RUN,
        G_FLUSH,
        G_WAIT,
        G_DRAIN
    } gen_state_t;

    function automatic logic [31:0] count_word(input logic [15:0] nbytes,
                                               input logic tail,
                                               input logic alt);
        logic [15:0] words_m1;
        words_m1 = {2'b00, nbytes[15:2]} - 16'd1;
        if (alt)
            return {words_m1, 16'h0000};
        else
            return {tail, 15'h0000, nbytes};
    endfunction

endpackage

// File: rtl/prd_piece_gen.sv
module prd_piece_gen
    import sgprd_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int MAX_ENTRIES = 256,
    parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             pc_valid,
    input  logic             pc_ready,
    output piece_t           pc,
    output logic             abort,
    input  logic             fin_ack,
    output logic             done,
    output logic             err_ovf,
    output logic             err_empty,
    output logic [CNT_W-1:0] desc_count
);
    localparam int EW = (LEN_W > 17) ? LEN_W : 17;

    gen_state_t       state;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] cur_rem;
    logic             cur_last;
    logic             half;
    logic [CNT_W-1:0] cnt;

    logic [EW-1:0]    rem_e, dist_e, step;
    logic             full, seg_end, at_limit;

    always_comb begin
        rem_e    = EW'(cur_rem);
        dist_e   = EW'(WINDOW_BYTES - {1'b0, cur_addr[15:0]});
        step     = (rem_e < dist_e) ? rem_e : dist_e;
        full     = (step == EW'(WINDOW_BYTES));
        seg_end  = (step == rem_e) && (!full || half);
        at_limit = (cnt == CNT_W'(MAX_ENTRIES));
        abort    = (state == G_RUN) && at_limit;

        pc_valid = ((state == G_RUN) && !at_limit) || (state == G_FLUSH);
        if (state == G_FLUSH) begin
            pc.addr     = '0;
            pc.nbytes   = '0;
            pc.tail     = 1'b1;
            pc.has_data = 1'b0;
        end else begin
            pc.addr     = cur_addr + (half ? 32'h0000_8000 : 32'h0);
            pc.nbytes   = full ? HALF_BYTES : step[15:0];
            pc.tail     = cur_last && seg_end;
            pc.has_data = 1'b1;
        end
        seg_ready = (state == G_IDLE) || (state == G_DRAIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= G_IDLE;
            cur_addr   <= '0;
            cur_rem    <= '0;
            cur_last   <= 1'b0;
            half       <= 1'b0;
            cnt        <= '0;
            done       <= 1'b0;
            err_ovf    <= 1'b0;
            err_empty  <= 1'b0;
            desc_count <= '0;
        end else begin
            done      <= 1'b0;
            err_ovf   <= 1'b0;
            err_empty <= 1'b0;
            unique case (state)
                G_IDLE: if (seg_valid) begin
                    if (seg_len == '0) begin
                        if (seg_last) begin
                            if (cnt == '0) begin
                                err_empty  <= 1'b1;
                                desc_count <= '0;
                            end else begin
                                state <= G_FLUSH;
                            end
                        end
                    end else begin
                        cur_addr <= seg_addr;
                        cur_rem  <= seg_len;
                        cur_last <= seg_last;
                        half     <= 1'b0;
                        state    <= G_RUN;
                    end
                end
                G_RUN: begin
                    if (at_limit) begin
                        err_ovf <= 1'b1;
                        cnt     <= '0;
                        half    <= 1'b0;
                        state   <= cur_last ? G_IDLE : G_DRAIN;
                    end else if (pc_ready) begin
                        cnt <= cnt + CNT_W'(1);
                        if (full && !half) begin
                            half <= 1'b1;
                        end else begin
                            half     <= 1'b0;
                            cur_addr <= cur_addr + 32'(step);
                            cur_rem  <= cur_rem - LEN_W'(step);
                            if (seg_end)
                                state <= cur_last ? G_WAIT : G_IDLE;
                        end
                    end
                end
                G_FLUSH: if (pc_ready) state <= G_WAIT;
                G_WAIT: if (fin_ack) begin
                    done       <= 1'b1;
                    desc_count <= cnt;
                    cnt        <= '0;
                    state      <= G_IDLE;
                end
                G_DRAIN: if (seg_valid && seg_last) state <= G_IDLE;
                default: state <= G_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/prd_hold_stage.sv
module prd_hold_stage
    import sgprd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  piece_t in_pc,
    input  logic   abort,
    output logic   out_valid,
    input  logic   out_ready,
    output piece_t out_pc
);
    logic   hv, hfin;
    piece_t held;

    always_comb begin
        out_valid   = hv && (hfin || (in_valid && in_pc.has_data));
        in_ready    = !hv || (!hfin && (!in_pc.has_data || out_ready));
        out_pc      = held;
        out_pc.tail = hfin;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            hv   <= 1'b0;
            hfin <= 1'b0;
            held <= '0;
        end else begin
            if (hv && hfin && out_ready) begin
                hv   <= 1'b0;
                hfin <= 1'b0;
            end
            if (in_valid && in_ready) begin
                if (in_pc.has_data) begin
                    hv   <= 1'b1;
                    held <= in_pc;
                    hfin <= in_pc.tail;
                end else if (hv) begin
                    hfin <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/prd_word_ser.sv
module prd_word_ser
    import sgprd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        alt,
    input  logic        in_valid,
    output logic        in_ready,
    input  piece_t      in_pc,
    output logic        word_valid,
    input  logic        word_ready,
    output logic [31:0] word_data,
    output logic        fin_ack
);
    logic   sv, ph;
    piece_t cur;

    always_comb begin
        in_ready   = !sv || (ph && word_ready);
        word_valid = sv;
        word_data  = ph ? count_word(cur.nbytes, cur.tail, alt) : cur.addr;
        fin_ack    = sv && ph && word_ready && cur.tail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sv  <= 1'b0;
            ph  <= 1'b0;
            cur <= '0;
        end else begin
            if (sv && word_ready) begin
                if (ph) begin
                    sv <= 1'b0;
                    ph <= 1'b0;
                end else begin
                    ph <= 1'b1;
                end
            end
            if (in_valid && in_ready) begin
                cur <= in_pc;
                sv  <= 1'b1;
                ph  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sg_prd_splitter.sv
module sg_prd_splitter
    import sgprd_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int MAX_ENTRIES = 256
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               alt_mode,
    input  logic                               seg_valid,
    output logic                               seg_ready,
    input  logic [31:0]                        seg_addr,
    input  logic [LEN_W-1:0]                   seg_len,
    input  logic                               seg_last,
    output logic                               word_valid,
    input  logic                               word_ready,
    output logic [31:0]                        word_data,
    output logic                               done,
    output logic                               err_overflow,
    output logic                               err_empty,
    output logic [$clog2(MAX_ENTRIES+1)-1:0]   desc_count
);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

    piece_t gen_pc, buf_pc;
    logic   gen_valid, gen_ready, abort;
    logic   buf_valid, buf_ready, fin_ack;

    prd_piece_gen #(
        .LEN_W      (LEN_W),
        .MAX_ENTRIES(MAX_ENTRIES),
        .CNT_W      (CNT_W)
    ) u_gen (
        .clk       (clk),
        .rst       (rst),
        .seg_valid (seg_valid),
        .seg_ready (seg_ready),
        .seg_addr  (seg_addr),
        .seg_len   (seg_len),
        .seg_last  (seg_last),
        .pc_valid  (gen_valid),
        .pc_ready  (gen_ready),
        .pc        (gen_pc),
        .abort     (abort),
        .fin_ack   (fin_ack),
        .done      (done),
        .err_ovf   (err_overflow),
        .err_empty (err_empty),
        .desc_count(desc_count)
    );

    prd_hold_stage u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (gen_valid),
        .in_ready (gen_ready),
        .in_pc    (gen_pc),
        .abort    (abort),
        .out_valid(buf_valid),
        .out_ready(buf_ready),
        .out_pc   (buf_pc)
    );

    prd_word_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .alt       (alt_mode),
        .in_valid  (buf_valid),
        .in_ready  (buf_ready),
        .in_pc     (buf_pc),
        .word_valid(word_valid),
        .word_ready(word_ready),
        .word_data (word_data),
        .fin_ack   (fin_ack)
    );

endmodule

// File: rtl/prd_split_chk.sv
module prd_split_chk #(
    parameter int MAX_ENTRIES = 256,
    parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             alt_mode,
    input logic             word_valid,
    input logic             word_ready,
    input logic [31:0]      word_data,
    input logic             done,
    input logic             err_overflow,
    input logic             err_empty,
    input logic [CNT_W-1:0] desc_count
);
    logic        ph;
    logic [15:0] low_addr;
    logic [16:0] span;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= 1'b0;
            low_addr <= '0;
        end else if (word_valid && word_ready) begin
            ph <= ~ph;
            if (!ph) low_addr <= word_data[15:0];
        end
    end

    assign span = {1'b0, low_addr} + {1'b0, word_data[15:0]};

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R9
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_overflow, err_empty}));

    // R9
    done_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (desc_count != '0 && desc_count <= CNT_W'(MAX_ENTRIES)));

    // R8
    empty_count_chk: assert property (@(posedge clk) disable iff (rst)
        err_empty |-> (desc_count == '0));

    // R5
    std_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && ph && !alt_mode) |-> (word_data[30:16] == '0 && word_data[15:0] != '0));

    // R6
    alt_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && ph && alt_mode) |-> (word_data[15:0] == '0));

    // R1
    no_cross_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && ph && !alt_mode) |-> (span <= 17'h10000));

endmodule

bind sg_prd_splitter prd_split_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alt_mode    (alt_mode),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .word_data   (word_data),
    .done        (done),
    .err_overflow(err_overflow),
    .err_empty   (err_empty),
    .desc_count  (desc_count)
);

// File: tb/tb_sg_prd_splitter.sv
module tb_sg_prd_splitter;
    localparam int LW   = 20;
    localparam int MAXE = 6;
    localparam int CW   = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alt_mode = 1'b0;
    logic          seg_valid = 1'b0;
    logic          seg_ready;
    logic [31:0]   seg_addr = '0;
    logic [LW-1:0] seg_len = '0;
    logic          seg_last = 1'b0;
    logic          word_valid;
    logic          word_ready = 1'b1;
    logic [31:0]   word_data;
    logic          done, err_overflow, err_empty;
    logic [CW-1:0] desc_count;

    always #4 clk = ~clk;

    sg_prd_splitter #(.LEN_W(LW), .MAX_ENTRIES(MAXE)) dut (
        .clk(clk), .rst(rst), .alt_mode(alt_mode),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .done(done), .err_overflow(err_overflow), .err_empty(err_empty),
        .desc_count(desc_count)
    );

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_w[$];
    int          exp_s[$];
    string       cur_req = "R11";
    logic [31:0] sa[8];
    logic [31:0] sl[8];
    int          ns = 0;
    bit          stall_on = 1'b0;
    logic [7:0]  lfsr = 8'h5a;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // consumer backpressure
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        word_ready = stall_on ? lfsr[0] : 1'b1;
    end

    // monitor: compares outputs against the scoreboard queues
    initial begin
        logic        prev_stall = 1'b0;
        logic [31:0] prev_data = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall)
                    check(word_valid && word_data == prev_data, "R10", word_data, prev_data);
                prev_stall = word_valid && !word_ready;
                prev_data  = word_data;
                if (word_valid && word_ready) begin
                    if (exp_w.size() == 0) begin
                        check(1'b0, cur_req, word_data, 32'hxxxxxxxx);
                    end else begin
                        logic [31:0] e;
                        e = exp_w.pop_front();
                        check(word_data == e, cur_req, word_data, e);
                    end
                end
                if (done || err_overflow || err_empty) begin
                    int code, e;
                    code = done ? 1000 + int'(desc_count) : (err_overflow ? 2000 : 3000 + int'(desc_count));
                    if (exp_s.size() == 0) e = -1;
                    else e = exp_s.pop_front();
                    check(code == e, cur_req, code, e);
                end
            end
        end
    end

    // reference model of the table for the segments in sa/sl
    task automatic build_expect(input bit alt);
        logic [31:0] pa[16];
        logic [15:0] pb[16];
        int          total = 0;
        int          nout;
        for (int i = 0; i < ns; i++) begin
            logic [31:0] a, r, d, b;
            a = sa[i];
            r = sl[i];
            while (r != 0) begin
                d = 32'h10000 - {16'h0, a[15:0]};
                b = (r < d) ? r : d;
                if (b == 32'h10000) begin
                    if (total < 16) begin pa[total] = a; pb[total] = 16'h8000; end
                    total++;
                    if (total < 16) begin pa[total] = a + 32'h8000; pb[total] = 16'h8000; end
                    total++;
                end else begin
                    if (total < 16) begin pa[total] = a; pb[total] = b[15:0]; end
                    total++;
                end
                a = a + b;
                r = r - b;
            end
        end
        if (total > MAXE) nout = MAXE - 1;
        else nout = total;
        for (int k = 0; k < nout; k++) begin
            logic tl;
            logic [15:0] wm1;
            tl  = (total <= MAXE) && (k == nout - 1);
            wm1 = {2'b00, pb[k][15:2]} - 16'd1;
            exp_w.push_back(pa[k]);
            exp_w.push_back(alt ? {wm1, 16'h0} : {tl, 15'h0, pb[k]});
        end
        if (total > MAXE) exp_s.push_back(2000);
        else if (total == 0) exp_s.push_back(3000);
        else exp_s.push_back(1000 + total);
    endtask

    task automatic send_seg(input int idx, input bit last);
        @(posedge clk);
        #1;
        seg_valid = 1'b1;
        seg_addr  = sa[idx];
        seg_len   = sl[idx][LW-1:0];
        seg_last  = last;
        do @(negedge clk); while (!seg_ready);
        @(posedge clk);
        #1;
        seg_valid = 1'b0;
        seg_last  = 1'b0;
    endtask

    task automatic run_table(input bit alt, input bit stall, input string req);
        int t = 0;
        alt_mode = alt;
        stall_on = stall;
        cur_req  = req;
        build_expect(alt);
        for (int i = 0; i < ns; i++) send_seg(i, i == ns - 1);
        while ((exp_w.size() != 0 || exp_s.size() != 0) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(t < 3000, req, exp_w.size(), 0);
        repeat (4) @(negedge clk);
        check(!word_valid, req, word_valid, 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!word_valid, "R11", word_valid, 0);
        check(seg_ready, "R11", seg_ready, 1);
        check(!done && !err_overflow && !err_empty, "R11", {done, err_overflow, err_empty}, 0);
        check(desc_count == 0, "R11", desc_count, 0);

        // R1 R2 single short segment
        ns = 1; sa[0] = 32'h1000_0000; sl[0] = 32'h200;
        run_table(1'b0, 1'b0, "R2");
        // R1 segment crossing a 64 KiB boundary
        ns = 1; sa[0] = 32'h0000_F000; sl[0] = 32'h3000;
        run_table(1'b0, 1'b0, "R1");
        // R1 piece ending exactly on the boundary
        ns = 1; sa[0] = 32'h0001_8000; sl[0] = 32'h8000;
        run_table(1'b0, 1'b1, "R1");
        // R3 full 64 KiB piece split into halves
        ns = 1; sa[0] = 32'h0002_0000; sl[0] = 32'h10000;
        run_table(1'b0, 1'b0, "R3");
        // R4 multi-segment with zero-length middle, exactly at the limit
        ns = 3;
        sa[0] = 32'h0000_5FFE; sl[0] = 32'h4;
        sa[1] = 32'h0000_1234; sl[1] = 32'h0;
        sa[2] = 32'h0001_FFF0; sl[2] = 32'h20010;
        run_table(1'b0, 1'b1, "R4");
        // R5 zero-length last segment closes the table
        ns = 2;
        sa[0] = 32'h4000_0100; sl[0] = 32'h80;
        sa[1] = 32'h0;         sl[1] = 32'h0;
        run_table(1'b0, 1'b0, "R5");
        // R8 empty table
        ns = 2;
        sa[0] = 32'h0; sl[0] = 32'h0;
        sa[1] = 32'h0; sl[1] = 32'h0;
        run_table(1'b0, 1'b0, "R8");
        // R6 alternate encoding
        ns = 1; sa[0] = 32'h3000_FFF0; sl[0] = 32'h20;
        run_table(1'b1, 1'b0, "R6");
        ns = 1; sa[0] = 32'h5000_0000; sl[0] = 32'h10000;
        run_table(1'b1, 1'b1, "R6");
        // R7 overflow inside a non-last segment, rest drained
        ns = 2;
        sa[0] = 32'h0;         sl[0] = 32'h38000;
        sa[1] = 32'h6000_0000; sl[1] = 32'h100;
        run_table(1'b0, 1'b1, "R7");
        // R9 recovery after overflow, limit reached exactly by halves
        ns = 1; sa[0] = 32'h0; sl[0] = 32'h30000;
        run_table(1'b0, 1'b0, "R9");
        // R7 overflow on the second half of a split piece
        ns = 2;
        sa[0] = 32'h0000_0100; sl[0] = 32'hFF00;
        sa[1] = 32'h0001_0000; sl[1] = 32'h30000;
        run_table(1'b0, 1'b0, "R7");
        // R2 normal table after the second overflow
        ns = 1; sa[0] = 32'h7777_0010; sl[0] = 32'h30;
        run_table(1'b0, 1'b1, "R2");
        finish_run();
    end

endmodule